// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block turns a processor-side sparse-space address into the description of one PCI memory or I/O cycle. In sparse space every PCI byte address is stretched by a factor of 32: the offset into the region is the PCI address shifted left by five. The five low bits carry the transfer description. Bits [4:3] give the length, and bits [2:0] are zero. The two bits just above them (offset bits [6:5], which are PCI address bits [1:0]) name the byte lane inside the 32-bit longword.

For memory cycles, only the low `KEEP_BITS` PCI address bits come from the shifted offset. The bits above them are taken from a programmable extension register, which software loads through a one-word write port. The block flags a memory request whose own upper bits disagree with the programmed extension value. For I/O cycles, the whole PCI address comes from the offset. The translator produces the PCI byte address, four active-high byte enables and a size code. It rejects length/lane combinations that cannot form a legal cycle. A 64-bit access is made by the requester as two longword requests, with the second one 0x80 higher in sparse offset.

Top module: `sparse_xlate`

## Requirements
- R1: After reset all outputs are zero and the extension register holds zero.
- R2: A request presented in one cycle produces exactly one of `cyc_valid` or `cyc_illegal` on the next clock edge. With no request, both are low and the address, enable, size, io and miss outputs are zero.
- R3: `cyc_size` equals offset bits [4:3] of a legal request. The encodings are 0 = byte, 1 = 16-bit word, 3 = 32-bit longword.
- R4: A byte request sets the single enable bit numbered by the lane (offset bits [6:5]).
- R5: A word request sets two adjacent enables starting at the lane. Lane 0 gives 0x3, lane 1 gives 0x6 and lane 2 gives 0xC.
- R6: A longword request at lane 0 sets all four enables (0xF).
- R7: Length code 2, a word at lane 3, and a longword at a nonzero lane raise `cyc_illegal`. No cycle is issued, and the address, enables, size and miss outputs are zero.
- R8: A memory cycle address takes PCI bits [KEEP_BITS-1:2] from offset bits [KEEP_BITS+4:7], forces bits [1:0] to zero, and takes bits above KEEP_BITS-1 from the same bits of the extension register. The default KEEP_BITS is 27.
- R9: An I/O cycle address is offset bits [36:5] unchanged, so bits [1:0] carry the lane.
- R10: A write strobe loads the extension register at the next edge. A request in the same cycle as the write still uses the old value.
- R11: `cyc_ext_miss` is set on a memory cycle whose offset bits above KEEP_BITS+4 differ from the extension register's bits above KEEP_BITS-1. It is never set on an I/O cycle.
- R12: Two longword requests 0x80 apart in sparse offset give PCI addresses 4 apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_io | input | 1 | 1 = I/O region, 0 = memory region |
| req_off | input | 37 | Sparse offset within the region |
| ext_we | input | 1 | Extension register write strobe |
| ext_wdata | input | 32 | Extension register write value |
| cyc_valid | output | 1 | A legal cycle is issued |
| cyc_illegal | output | 1 | The request had an illegal length/lane |
| cyc_io | output | 1 | The issued cycle is I/O |
| cyc_addr | output | 32 | PCI byte address |
| cyc_be | output | 4 | Active-high byte enables |
| cyc_size | output | 2 | Transfer length code |
| cyc_ext_miss | output | 1 | Memory upper bits disagree with the extension register |

## Verification
The hardest case to reach is a request and an extension write in the same cycle, because the old and new register values differ only in that one cycle. The stimulus issues a memory longword together with a write of a new upper value. It then repeats the same request one cycle later. The first result must show the old upper bits with the miss flag set, and the second must show the new bits with the flag clear. Back-to-back requests, including the quadword pair, also check that each result lands exactly one cycle after its request.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'd0,
    LEN_WORD = 2'd1,
    LEN_RSVD = 2'd2,
    LEN_LONG = 2'd3
  } len_e;

  // Byte enables for a given length starting at the given lane.
  function automatic logic [3:0] lane_enables(len_e len, logic [1:0] lane);
    logic [3:0] be;
    unique case (len)
      LEN_BYTE: be = 4'b0001 << lane;
      LEN_WORD: be = 4'b0011 << lane;
      LEN_LONG: be = 4'b1111;
      default:  be = 4'b0000;
    endcase
    return be;
  endfunction

  // A combination that cannot form one legal PCI cycle.
  function automatic logic bad_combo(len_e len, logic [1:0] lane);
    logic bad;
    unique case (len)
      LEN_BYTE: bad = 1'b0;
      LEN_WORD: bad = (lane == 2'd3);
      LEN_LONG: bad = (lane != 2'd0);
      default:  bad = 1'b1;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/sxl_field_split.sv
module sxl_field_split
  import sxl_pkg::*;
#(
  parameter int PCI_W = 32,
  parameter int OFF_W = PCI_W + 5
) (
  input  logic [OFF_W-1:0] off,
  output len_e             len,
  output logic [1:0]       lane,
  output logic [PCI_W-1:0] pci_raw
);
  // Offset bits [4:3] carry the length; the PCI address sits above bit 4.
  assign len     = len_e'(off[4:3]);
  assign pci_raw = off[OFF_W-1:5];
  assign lane    = pci_raw[1:0];
endmodule

// File: rtl/sxl_ext_reg.sv
module sxl_ext_reg #(
  parameter int PCI_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PCI_W-1:0] wdata,
  output logic [PCI_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  p_ext_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  p_ext_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/sxl_addr_form.sv
module sxl_addr_form #(
  parameter int PCI_W     = 32,
  parameter int KEEP_BITS = 27
) (
  input  logic             io,
  input  logic [PCI_W-1:0] pci_raw,
  input  logic [PCI_W-1:0] ext,
  output logic [PCI_W-1:0] addr,
  output logic             miss
);
  localparam logic [PCI_W-1:0] ONE      = {{(PCI_W-1){1'b0}}, 1'b1};
  localparam logic [PCI_W-1:0] LOW_MASK = (ONE << KEEP_BITS) - ONE;

  logic [PCI_W-1:0] mem_addr;
  logic             upper_differs;

  always_comb begin
    mem_addr      = (pci_raw & LOW_MASK) | (ext & ~LOW_MASK);
    mem_addr[1:0] = 2'b00;
  end

  assign upper_differs = ((pci_raw ^ ext) & ~LOW_MASK) != '0;
  assign addr          = io ? pci_raw : mem_addr;
  assign miss          = !io && upper_differs;
endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
  import sxl_pkg::*;
#(
  parameter  int PCI_W     = 32,
  parameter  int KEEP_BITS = 27,
  localparam int OFF_W     = PCI_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_io,
  input  logic [OFF_W-1:0] req_off,
  input  logic             ext_we,
  input  logic [PCI_W-1:0] ext_wdata,
  output logic             cyc_valid,
  output logic             cyc_illegal,
  output logic             cyc_io,
  output logic [PCI_W-1:0] cyc_addr,
  output logic [3:0]       cyc_be,
  output logic [1:0]       cyc_size,
  output logic             cyc_ext_miss
);
  len_e             len;
  logic [1:0]       lane;
  logic [PCI_W-1:0] pci_raw;
  logic [PCI_W-1:0] ext_q;
  logic [PCI_W-1:0] addr_n;
  logic             miss_n;
  logic             bad_n;
  logic             issue_n;
  logic             reject_n;

  sxl_field_split #(.PCI_W(PCI_W), .OFF_W(OFF_W)) u_split (
    .off(req_off), .len(len), .lane(lane), .pci_raw(pci_raw)
  );

  sxl_ext_reg #(.PCI_W(PCI_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .we(ext_we), .wdata(ext_wdata), .q(ext_q)
  );

  sxl_addr_form #(.PCI_W(PCI_W), .KEEP_BITS(KEEP_BITS)) u_form (
    .io(req_io), .pci_raw(pci_raw), .ext(ext_q), .addr(addr_n), .miss(miss_n)
  );

  assign bad_n    = bad_combo(len, lane);
  assign issue_n  = req_valid && !bad_n;
  assign reject_n = req_valid && bad_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid    <= 1'b0;
      cyc_illegal  <= 1'b0;
      cyc_io       <= 1'b0;
      cyc_addr     <= '0;
      cyc_be       <= '0;
      cyc_size     <= '0;
      cyc_ext_miss <= 1'b0;
    end else begin
      cyc_valid    <= issue_n;
      cyc_illegal  <= reject_n;
      cyc_io       <= issue_n && req_io;
      cyc_addr     <= issue_n ? addr_n : '0;
      cyc_be       <= issue_n ? lane_enables(len, lane) : 4'b0000;
      cyc_size     <= issue_n ? 2'(len) : 2'b00;
      cyc_ext_miss <= issue_n && miss_n;
    end
  end

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (cyc_valid ^ cyc_illegal));
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!cyc_valid && !cyc_illegal && cyc_be == 4'b0000));
  p_byte_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_size == 2'd0) |-> $onehot0(cyc_be) && cyc_be != 4'b0000);
  p_word_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_size == 2'd1) |-> $countones(cyc_be) == 2);
  p_long_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_size == 2'd3) |-> cyc_be == 4'b1111);
  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_illegal |-> (!cyc_valid && cyc_be == 4'b0000 && !cyc_ext_miss));
  p_mem_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_io) |-> cyc_addr[1:0] == 2'b00);
  p_io_no_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_io |-> !cyc_ext_miss);
endmodule

// File: tb/tb_sparse_xlate.sv
module tb_sparse_xlate;
  localparam int PCI_W = 32;
  localparam int OFF_W = 37;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_io = 1'b0;
  logic [OFF_W-1:0] req_off = '0;
  logic             ext_we = 1'b0;
  logic [PCI_W-1:0] ext_wdata = '0;
  logic             cyc_valid, cyc_illegal, cyc_io, cyc_ext_miss;
  logic [PCI_W-1:0] cyc_addr;
  logic [3:0]       cyc_be;
  logic [1:0]       cyc_size;

  sparse_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
    .req_off(req_off), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .cyc_valid(cyc_valid), .cyc_illegal(cyc_illegal), .cyc_io(cyc_io),
    .cyc_addr(cyc_addr), .cyc_be(cyc_be), .cyc_size(cyc_size),
    .cyc_ext_miss(cyc_ext_miss)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          cyc;
    logic        valid;
    logic        illegal;
    logic        io;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [1:0]  size;
    logic        miss;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc_cnt = 0;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] ext_model = '0;
  logic        mon_on = 1'b0;
  logic        done = 1'b0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [3:0] model_be(logic [1:0] len, logic [1:0] lane);
    case (len)
      2'd0: case (lane) 2'd0: return 4'h1; 2'd1: return 4'h2; 2'd2: return 4'h4; default: return 4'h8; endcase
      2'd1: case (lane) 2'd0: return 4'h3; 2'd1: return 4'h6; 2'd2: return 4'hC; default: return 4'h0; endcase
      2'd3: return (lane == 2'd0) ? 4'hF : 4'h0;
      default: return 4'h0;
    endcase
  endfunction

  task automatic send(input logic io, input logic [31:0] pci, input logic [1:0] len,
                      input logic wr, input logic [31:0] wval, input string tag);
    exp_t e;
    logic [1:0] lane;
    logic bad;
    @(negedge clk);
    req_valid = 1'b1;
    req_io    = io;
    req_off   = {pci, len, 3'b000};
    ext_we    = wr;
    ext_wdata = wval;
    lane = pci[1:0];
    bad  = (len == 2'd2) || (len == 2'd1 && lane == 2'd3) || (len == 2'd3 && lane != 2'd0);
    e.cyc = cyc_cnt;
    e.tag = tag;
    e.valid = !bad;
    e.illegal = bad;
    e.io = !bad && io;
    e.size = bad ? 2'd0 : len;
    e.be = bad ? 4'h0 : model_be(len, lane);
    if (bad)     e.addr = 32'h0;
    else if (io) e.addr = pci;
    else         e.addr = {ext_model[31:27], pci[26:2], 2'b00};
    e.miss = !bad && !io && (pci[31:27] != ext_model[31:27]);
    sb.push_back(e);
    if (wr) ext_model = wval;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_io    = 1'b0;
    req_off   = '0;
    ext_we    = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      n_run++;
      if (sb.size() > 0 && sb[0].cyc + 1 == cyc_cnt) begin
        exp_t e;
        e = sb.pop_front();
        if (cyc_valid !== e.valid || cyc_illegal !== e.illegal || cyc_io !== e.io ||
            cyc_addr !== e.addr || cyc_be !== e.be || cyc_size !== e.size ||
            cyc_ext_miss !== e.miss) begin
          n_fail++;
          $display("FAIL %s: got v=%b ill=%b io=%b addr=%h be=%h sz=%0d miss=%b exp v=%b ill=%b io=%b addr=%h be=%h sz=%0d miss=%b",
            e.tag, cyc_valid, cyc_illegal, cyc_io, cyc_addr, cyc_be, cyc_size, cyc_ext_miss,
            e.valid, e.illegal, e.io, e.addr, e.be, e.size, e.miss);
        end
      end else if (cyc_valid !== 1'b0 || cyc_illegal !== 1'b0 || cyc_be !== 4'h0 ||
                   cyc_addr !== 32'h0 || cyc_ext_miss !== 1'b0) begin
        n_fail++;
        $display("FAIL R2 idle: got v=%b ill=%b addr=%h be=%h exp all zero",
          cyc_valid, cyc_illegal, cyc_addr, cyc_be);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    n_run++;
    if (cyc_valid || cyc_illegal || cyc_io || cyc_addr != 0 || cyc_be != 0 || cyc_size != 0 || cyc_ext_miss) begin
      n_fail++;
      $display("FAIL R1 reset: got addr=%h be=%h exp zeros", cyc_addr, cyc_be);
    end
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    // R1 ext reg zero: memory result has zero upper bits and no miss
    send(1'b0, 32'h0000_1230, 2'd0, 1'b0, 0, "R1 R4 mem byte lane0");
    send(1'b0, 32'h0000_1233, 2'd0, 1'b0, 0, "R4 mem byte lane3");
    send(1'b0, 32'h0000_2001, 2'd0, 1'b0, 0, "R4 R8 byte lane1 addr low zero");
    send(1'b0, 32'h0000_4000, 2'd1, 1'b0, 0, "R3 R5 word lane0");
    send(1'b0, 32'h0000_4001, 2'd1, 1'b0, 0, "R5 word lane1");
    send(1'b0, 32'h0000_4002, 2'd1, 1'b0, 0, "R5 word lane2");
    send(1'b0, 32'h0000_8000, 2'd3, 1'b0, 0, "R3 R6 long lane0");
    send(1'b0, 32'h0000_4003, 2'd1, 1'b0, 0, "R7 word lane3");
    send(1'b0, 32'h0000_8001, 2'd3, 1'b0, 0, "R7 long lane1");
    send(1'b0, 32'h0000_8000, 2'd2, 1'b0, 0, "R7 length code 2");
    idle();
    send(1'b1, 32'h0000_03F1, 2'd0, 1'b0, 0, "R9 io byte lane1");
    send(1'b1, 32'hC000_0CF8, 2'd3, 1'b0, 0, "R9 R11 io long high bits no miss");
    send(1'b1, 32'h0000_0302, 2'd1, 1'b0, 0, "R9 io word lane2");
    // R10: write and request in the same cycle use the old value
    send(1'b0, 32'hA812_3450, 2'd3, 1'b1, 32'hA800_0000, "R10 R11 same-cycle old ext miss");
    send(1'b0, 32'hA812_3450, 2'd3, 1'b0, 0, "R10 R8 new ext applied");
    send(1'b0, 32'hB012_3450, 2'd3, 1'b0, 0, "R11 upper mismatch");
    idle();
    // R12: quadword as two longwords 0x80 apart in sparse offset
    send(1'b0, 32'hA800_7F00, 2'd3, 1'b0, 0, "R12 qword low half");
    send(1'b0, 32'hA800_7F04, 2'd3, 1'b0, 0, "R12 qword high half");
    idle();
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2 pending: got %0d results missing exp 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule